// File: doc/BRIEF.md
# Memory Slot Hotplug Register Block

This block tells firmware which memory slots are populated and raises an interrupt when that changes. A slot controller reports each insertion or removal on a one-cycle event input that carries a slot index and an add/remove flag. The block keeps one presence bit per slot, and firmware reads the bits a byte at a time over an 8-bit I/O bus. Either kind of event also sets a memory-hotplug flag in an event status byte. When a status bit is set and its enable bit is set, a level interrupt output goes high.

When firmware has finished taking a slot out of service, it writes that slot's number to a write-only eject byte. The block answers the write with a one-cycle completion pulse that carries the written number. The status byte is cleared by writing ones to it. The enable byte is a plain read/write register.

Top module: `mem_hotplug_regs`

## Requirements
- R1: After reset, every byte of the presence map reads 0x00, the status and enable bytes read 0x00, and the interrupt and eject pulse outputs are low.
- R2: A hot-add event for slot n sets bit n mod 8 of the map byte at address 0xAF80 + n/8. The new value is readable from the clock edge that takes in the event.
- R3: A hot-remove event for slot n clears that same bit and leaves every other slot's bit unchanged.
- R4: Writes to any address from 0xAF80 to 0xAF9F leave the presence map unchanged.
- R5: A write to 0xAFA0 raises the eject pulse for exactly one cycle after the write edge, with the eject slot output equal to the written byte. No other write raises the pulse.
- R6: Every add or remove event sets bit 3 (0x08) of the status byte at 0xAFA8.
- R7: Writing a byte to 0xAFA8 clears each status bit that is 1 in that byte. A write to 0xAFA9 loads the enable byte, and reading 0xAFA9 returns it.
- R8: The interrupt is high exactly when (status AND enable AND 0x0A) is nonzero. It updates on the same edge as the register change that causes it.
- R9: Read data appears the cycle after the read strobe. A read of 0xAFA0 or of any unmapped address returns 0x00, and the read data output is 0x00 in any cycle after a cycle with no read strobe.
- R10: If an event and a write-one-to-clear of bit 3 arrive in the same cycle, bit 3 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, one cycle after the strobe |
| hp_valid | input | 1 | Hotplug event strobe |
| hp_slot | input | 8 | Slot index of the event |
| hp_add | input | 1 | 1 for insertion, 0 for removal |
| eject_pulse | output | 1 | One-cycle removal-complete pulse |
| eject_slot | output | 8 | Slot number written to the eject byte |
| sci_level | output | 1 | Level interrupt |

## Verification
The bench adds and removes slots in interleaved patterns across all 32 map bytes, so a swapped byte index or bit index shows up as the wrong bit set in a neighbouring byte. Writes of 0xFF into the map range catch a map that accepts bus writes. The enable byte is stepped through values that do and do not overlap status bit 3, which catches an interrupt equation with the wrong mask or with the enable left out. The bench also clears status bit 3 in the same cycle as an event, which exposes a design where the clear wins. Reads of the eject byte and of unmapped addresses catch a decoder that leaks data.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int DATA_W      = 8;
    localparam int EVT_PCI_BIT = 1;
    localparam int EVT_MEM_BIT = 3;
    localparam logic [DATA_W-1:0] EVT_MEM_MASK = DATA_W'(1) << EVT_MEM_BIT;
    localparam logic [DATA_W-1:0] EVT_PCI_MASK = DATA_W'(1) << EVT_PCI_BIT;
    localparam logic [DATA_W-1:0] IRQ_SRC_MASK = EVT_MEM_MASK | EVT_PCI_MASK;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MAP,
        SEL_STS,
        SEL_EN
    } rd_sel_e;
endpackage

// File: rtl/hp_slot_map.sv
module hp_slot_map #(
    parameter int NUM_SLOTS = 256,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int MAP_BYTES = NUM_SLOTS / 8,
    localparam int IDX_W     = $clog2(MAP_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic                 evt_add,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_byte,
    output logic [NUM_SLOTS-1:0] present
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] bits;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (evt_valid && (int'(evt_slot) < NUM_SLOTS)) begin
            map_d.bits[evt_slot] = evt_add;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign rd_byte = map_q.bits[{rd_idx, 3'b000} +: 8];
    assign present = map_q.bits;
endmodule

// File: rtl/hp_event_regs.sv
module hp_event_regs
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              sts_we,
    input  logic              en_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sts,
    output logic [DATA_W-1:0] en,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] sts;
        logic [DATA_W-1:0] en;
        logic              irq;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d     = ev_q;
        if (sts_we) begin
            ev_d.sts = ev_q.sts & ~wdata;
        end
        if (evt_valid) begin
            ev_d.sts = ev_d.sts | EVT_MEM_MASK;
        end
        if (en_we) begin
            ev_d.en = wdata;
        end
        ev_d.irq = |(ev_d.sts & ev_d.en & IRQ_SRC_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign sts = ev_q.sts;
    assign en  = ev_q.en;
    assign irq = ev_q.irq;
endmodule

// File: rtl/hp_eject_port.sv
module hp_eject_port
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              pulse,
    output logic [DATA_W-1:0] slot
);
    typedef struct packed {
        logic              pulse;
        logic [DATA_W-1:0] slot;
    } ej_t;

    ej_t ej_d, ej_q;

    always_comb begin
        ej_d.pulse = we;
        ej_d.slot  = we ? wdata : ej_q.slot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ej_q <= '0;
        end else begin
            ej_q <= ej_d;
        end
    end

    assign pulse = ej_q.pulse;
    assign slot  = ej_q.slot;
endmodule

// File: rtl/mem_hotplug_regs.sv
module mem_hotplug_regs
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 256,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MAP_BASE  = 16'hAF80,
    parameter logic [ADDR_W-1:0] EJECT_ADR = 16'hAFA0,
    parameter logic [ADDR_W-1:0] STS_ADR   = 16'hAFA8,
    parameter logic [ADDR_W-1:0] EN_ADR    = 16'hAFA9,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int MAP_BYTES = NUM_SLOTS / 8,
    localparam int IDX_W     = $clog2(MAP_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              hp_valid,
    input  logic [SLOT_W-1:0] hp_slot,
    input  logic              hp_add,
    output logic              eject_pulse,
    output logic [DATA_W-1:0] eject_slot,
    output logic              sci_level
);
    localparam logic [ADDR_W-1:0] MAP_LAST = MAP_BASE + ADDR_W'(MAP_BYTES - 1);

    logic [ADDR_W-1:0]    map_off;
    logic                 in_map;
    rd_sel_e              rd_sel;
    logic [7:0]           map_byte;
    logic [NUM_SLOTS-1:0] map_bits;
    logic [DATA_W-1:0]    sts_q;
    logic [DATA_W-1:0]    en_q;
    logic                 sts_we;
    logic                 en_we;
    logic                 ej_we;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    assign map_off = io_addr - MAP_BASE;
    assign in_map  = (io_addr >= MAP_BASE) && (io_addr <= MAP_LAST);
    assign sts_we  = io_wr && (io_addr == STS_ADR);
    assign en_we   = io_wr && (io_addr == EN_ADR);
    assign ej_we   = io_wr && (io_addr == EJECT_ADR);

    always_comb begin
        if (in_map) begin
            rd_sel = SEL_MAP;
        end else if (io_addr == STS_ADR) begin
            rd_sel = SEL_STS;
        end else if (io_addr == EN_ADR) begin
            rd_sel = SEL_EN;
        end else begin
            rd_sel = SEL_NONE;
        end
    end

    hp_slot_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(hp_valid),
        .evt_slot (hp_slot),
        .evt_add  (hp_add),
        .rd_idx   (map_off[IDX_W-1:0]),
        .rd_byte  (map_byte),
        .present  (map_bits)
    );

    hp_event_regs u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(hp_valid),
        .sts_we   (sts_we),
        .en_we    (en_we),
        .wdata    (io_wdata),
        .sts      (sts_q),
        .en       (en_q),
        .irq      (sci_level)
    );

    hp_eject_port u_ej (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ej_we),
        .wdata(io_wdata),
        .pulse(eject_pulse),
        .slot (eject_slot)
    );

    always_comb begin
        top_d.rdata = '0;
        if (io_rd) begin
            unique case (rd_sel)
                SEL_MAP:  top_d.rdata = map_byte;
                SEL_STS:  top_d.rdata = sts_q;
                SEL_EN:   top_d.rdata = en_q;
                default:  top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign io_rdata = top_q.rdata;
endmodule

// File: rtl/mem_hotplug_regs_chk.sv
module mem_hotplug_regs_chk #(
    parameter int NUM_SLOTS = 256,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MAP_BASE  = 16'hAF80,
    parameter logic [ADDR_W-1:0] EJECT_ADR = 16'hAFA0,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int MAP_BYTES = NUM_SLOTS / 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic                 hp_valid,
    input logic [SLOT_W-1:0]    hp_slot,
    input logic                 hp_add,
    input logic                 eject_pulse,
    input logic [7:0]           eject_slot,
    input logic                 sci_level,
    input logic [7:0]           sts_q,
    input logic [7:0]           en_q,
    input logic [NUM_SLOTS-1:0] map_bits
);
    localparam logic [ADDR_W-1:0] MAP_LAST = MAP_BASE + ADDR_W'(MAP_BYTES - 1);

    p_add_sets_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && hp_add) |=> map_bits[$past(hp_slot)]);

    p_remove_clears_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && !hp_add) |=> !map_bits[$past(hp_slot)]);

    p_map_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !hp_valid && io_addr >= MAP_BASE && io_addr <= MAP_LAST) |=> $stable(map_bits));

    p_eject_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == EJECT_ADR) |=> (eject_pulse && eject_slot == $past(io_wdata)));

    p_no_stray_eject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == EJECT_ADR) |=> !eject_pulse);

    // R10: the event sets bit 3 even when a clear arrives in the same cycle
    p_event_sets_sts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> sts_q[3]);

    p_irq_equation_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sci_level == ((sts_q & en_q & 8'h0A) != 8'h00));

    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> io_rdata == 8'h00);
endmodule

bind mem_hotplug_regs mem_hotplug_regs_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W),
    .MAP_BASE (MAP_BASE),
    .EJECT_ADR(EJECT_ADR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .hp_valid   (hp_valid),
    .hp_slot    (hp_slot),
    .hp_add     (hp_add),
    .eject_pulse(eject_pulse),
    .eject_slot (eject_slot),
    .sci_level  (sci_level),
    .sts_q      (sts_q),
    .en_q       (en_q),
    .map_bits   (map_bits)
);

// File: tb/mem_hotplug_regs_test.sv
module mem_hotplug_regs_test;
    localparam logic [15:0] MAP_BASE = 16'hAF80;
    localparam logic [15:0] EJ_ADR   = 16'hAFA0;
    localparam logic [15:0] STS_ADR  = 16'hAFA8;
    localparam logic [15:0] EN_ADR   = 16'hAFA9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        hp_valid = 1'b0;
    logic [7:0]  hp_slot = '0;
    logic        hp_add = 1'b0;
    logic        eject_pulse;
    logic [7:0]  eject_slot;
    logic        sci_level;

    int checks = 0;
    int errors = 0;
    logic [255:0] model = '0;
    logic [7:0]   rd;
    bit done = 0;

    always #4 clk = ~clk;

    mem_hotplug_regs uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hp_valid(hp_valid), .hp_slot(hp_slot),
        .hp_add(hp_add), .eject_pulse(eject_pulse), .eject_slot(eject_slot),
        .sci_level(sci_level)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic hp_event(input logic [7:0] s, input logic add);
        hp_valid = 1'b1; hp_slot = s; hp_add = add;
        @(posedge clk); @(negedge clk);
        hp_valid = 1'b0;
        model[s] = add;
    endtask

    task automatic sweep_map(input string req);
        for (int b = 0; b < 32; b++) begin
            io_read(MAP_BASE + 16'(b), rd);
            check(req, rd, model[b*8 +: 8]);
        end
    endtask

    function automatic logic [7:0] irq_exp(input logic [7:0] s, input logic [7:0] e);
        return ((s & e & 8'h0A) != 0) ? 8'h01 : 8'h00;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 sci", {7'b0, sci_level}, 8'h00);
        check("R1 eject", {7'b0, eject_pulse}, 8'h00);
        sweep_map("R1 map");
        io_read(STS_ADR, rd); check("R1 sts", rd, 8'h00);
        io_read(EN_ADR, rd);  check("R1 en", rd, 8'h00);

        // R2 add every third slot, check the affected byte after each event
        for (int s = 0; s < 256; s += 3) begin
            hp_event(8'(s), 1'b1);
            io_read(MAP_BASE + 16'(s / 8), rd);
            check("R2 add", rd, model[(s / 8) * 8 +: 8]);
        end
        sweep_map("R2 sweep");
        io_read(STS_ADR, rd); check("R6 add sts", rd, 8'h08);
        check("R8 en=0", {7'b0, sci_level}, 8'h00);

        // R7/R8 enable patterns
        io_write(EN_ADR, 8'h08); check("R8 en=08", {7'b0, sci_level}, irq_exp(8'h08, 8'h08));
        io_write(EN_ADR, 8'h02); check("R8 en=02", {7'b0, sci_level}, irq_exp(8'h08, 8'h02));
        io_write(EN_ADR, 8'hF7); check("R8 en=F7", {7'b0, sci_level}, irq_exp(8'h08, 8'hF7));
        io_write(EN_ADR, 8'hFF); check("R8 en=FF", {7'b0, sci_level}, irq_exp(8'h08, 8'hFF));
        io_read(EN_ADR, rd); check("R7 en readback", rd, 8'hFF);

        // R7 write-one-to-clear: a zero-bit write keeps it, a one clears it
        io_write(STS_ADR, 8'hF7);
        io_read(STS_ADR, rd); check("R7 w1c keep", rd, 8'h08);
        check("R8 still high", {7'b0, sci_level}, 8'h01);
        io_write(STS_ADR, 8'h08);
        check("R8 after clear", {7'b0, sci_level}, 8'h00);
        io_read(STS_ADR, rd); check("R7 w1c clear", rd, 8'h00);

        // R4 writes into the map range
        for (int b = 0; b < 32; b += 5) io_write(MAP_BASE + 16'(b), 8'hFF);
        io_write(MAP_BASE + 16'd31, 8'h00);
        sweep_map("R4 map write");

        // R3 remove every sixth slot
        for (int s = 0; s < 256; s += 6) begin
            hp_event(8'(s), 1'b0);
            io_read(MAP_BASE + 16'(s / 8), rd);
            check("R3 remove", rd, model[(s / 8) * 8 +: 8]);
        end
        sweep_map("R3 sweep");
        io_read(STS_ADR, rd); check("R6 remove sts", rd, 8'h08);
        check("R8 remove irq", {7'b0, sci_level}, 8'h01);

        // R2 boundary slots
        hp_event(8'd255, 1'b1); hp_event(8'd1, 1'b1);
        sweep_map("R2 edges");

        // R5 eject
        io_write(EJ_ADR, 8'h5A);
        check("R5 pulse", {7'b0, eject_pulse}, 8'h01);
        check("R5 slot", eject_slot, 8'h5A);
        @(negedge clk);
        check("R5 one cycle", {7'b0, eject_pulse}, 8'h00);
        io_write(EJ_ADR, 8'hFF);
        check("R5 slot FF", eject_slot, 8'hFF);
        io_write(EN_ADR, 8'hFF);
        check("R5 no stray", {7'b0, eject_pulse}, 8'h00);
        sweep_map("R5 map untouched");

        // R9 reads of eject and unmapped addresses
        io_read(EJ_ADR, rd);       check("R9 eject read", rd, 8'h00);
        io_read(16'hAFA1, rd);     check("R9 unmapped", rd, 8'h00);
        io_read(16'h0000, rd);     check("R9 zero addr", rd, 8'h00);
        io_read(MAP_BASE - 16'd1, rd); check("R9 below map", rd, 8'h00);
        @(negedge clk);
        check("R9 idle", io_rdata, 8'h00);

        // R10 event and clear collide
        io_write(STS_ADR, 8'hFF);
        io_read(STS_ADR, rd); check("R10 pre", rd, 8'h00);
        hp_valid = 1'b1; hp_slot = 8'd9; hp_add = 1'b1;
        io_addr = STS_ADR; io_wdata = 8'h08; io_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        hp_valid = 1'b0; io_wr = 1'b0; model[9] = 1'b1;
        io_read(STS_ADR, rd); check("R10 sts", rd, 8'h08);
        check("R10 irq", {7'b0, sci_level}, 8'h01);
        sweep_map("R10 map");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule